// File: doc/BRIEF.md
# EPP Cycle Engine with Hung-Cycle Watchdog

This block runs enhanced parallel port (EPP) address and data cycles on behalf of a host. The host sees four byte-wide registers. When the port is in EPP mode, a read or write of the address port or the data port register starts a hardware handshake on the cable. The engine sets the write line and the data direction and lowers one strobe. It then waits for the peripheral to raise WAIT#, releases the strobe, and waits for WAIT# to fall before it completes the host access. Until then the host access stays stalled, with `host_ack_o` low.

A peripheral that is missing or faulty would otherwise stall the host for ever. A cycle counter guards every cycle and runs only in EPP mode. When it expires, the engine abandons the handshake, releases the port, completes the host access and latches a timeout flag in the status register. Software clears that flag by writing 1 to it. The counter length is the parameter `TMO_CYCLES`. Its default is 2,500,000 cycles, which is 10 ms at a 250 MHz clock. WAIT# passes through a synchronizer of `SYNC_STAGES` flops before the engine uses it.

Top module: `epp_engine`

## Requirements
- R1: After reset both strobes and the write line are high, `pd_oe_o` is 0, `host_ack_o` is 0, the mode register reads 0 and the status register reads 0.
- R2: A port cycle starts only when the mode field, bits 7:5 of the mode register at address 1, equals 3'b100. In any other mode, an access to address 2 or 3 is acknowledged with no strobe and returns 0, and a write to those addresses is discarded.
- R3: An access to address 2 (address port) lowers only `addr_strobe_no`. An access to address 3 (data port) lowers only `data_strobe_no`. The two strobes are never low at the same time.
- R4: For a port write, `wr_line_no` is low, `pd_oe_o` is 1 and `pd_o` carries the host byte during the clock cycle before the strobe falls, and they stay so while the strobe is low.
- R5: For a port read, `wr_line_no` stays high and `pd_oe_o` stays 0. The byte on `pd_i` while WAIT# is high is returned on `host_rdata_o` with `host_ack_o`.
- R6: The strobe stays low until WAIT# is seen high, and it is then released. `host_ack_o` is a single-cycle pulse that for a completed cycle comes only after WAIT# has fallen again.
- R7: If WAIT# stays low, the strobe is held low for exactly `TMO_CYCLES` clock cycles and then released. The access is acknowledged, a read returns 8'hFF, and status bit 0 (timeout flag) becomes 1.
- R8: If WAIT# rises but never falls, the watchdog still aborts the cycle. The access is acknowledged and status bit 0 becomes 1.
- R9: Writing a byte with bit 0 set to address 0 clears the timeout flag. Writing a byte with bit 0 clear leaves the flag unchanged.
- R10: Outside EPP mode the watchdog is held cleared, so port accesses in that state never set the timeout flag.
- R11: The mode register reads back bits 7:5 as written and bits 4:0 as 0. A mode field other than 3'b100, for example 3'b111, is not EPP mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request, held until acknowledged |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 2 | 0 status, 1 mode, 2 address port, 3 data port |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, valid with ack |
| host_ack_o | output | 1 | One-cycle access completion |
| pd_o | output | 8 | Port data driven to the peripheral |
| pd_i | input | 8 | Port data from the peripheral |
| pd_oe_o | output | 1 | Port data output enable |
| wr_line_no | output | 1 | Write direction line, low for writes |
| addr_strobe_no | output | 1 | Address strobe, active low |
| data_strobe_no | output | 1 | Data strobe, active low |
| periph_wait_i | input | 1 | WAIT# line level, high = peripheral ready |

## Verification
The hardest case to reach is the abort while WAIT# is already high but never falls. Here the watchdog must keep running across the strobe release. The bench reaches it with a peripheral model that can be switched between three behaviours: normal handshaking with chosen delays, never responding, and raising WAIT# and then holding it. A scoreboard pairs every strobe with the access the driver queued. It also counts strobe-low cycles, so that the abort length can be checked to the exact cycle.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} epp_state_e;
  localparam logic [1:0] ADDR_STAT  = 2'd0;
  localparam logic [1:0] ADDR_MODE  = 2'd1;
  localparam logic [1:0] ADDR_APORT = 2'd2;
  localparam logic [1:0] ADDR_DPORT = 2'd3;
  localparam logic [2:0] MODE_EPP   = 3'b100;
  localparam logic [7:0] ABORT_BYTE = 8'hFF;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int unsigned TMO_CYCLES = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          active;

  assign active    = enable_i && run_i;
  assign expired_o = active && (cnt_q == LAST);

  // counter is held at zero outside EPP mode and between cycles
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  cnt_q <= '0;
    else if (!active || expired_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;

  a_r7_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r10_held_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> cnt_q == '0);
endmodule

// File: rtl/epp_regs.sv
module epp_regs
  import epp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [2:0] mode_d_i,
  input  logic       stat_we_i,
  input  logic       stat_clr_i,
  input  logic       tmo_set_i,
  output logic [2:0] mode_o,
  output logic       tmo_flag_o,
  output logic       epp_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        mode_o <= '0;
    else if (mode_we_i) mode_o <= mode_d_i;

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       tmo_flag_o <= 1'b0;
    else if (tmo_set_i)                tmo_flag_o <= 1'b1;
    else if (stat_we_i && stat_clr_i)  tmo_flag_o <= 1'b0;

  assign epp_mode_o = (mode_o == MODE_EPP);

  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_set_i |=> tmo_flag_o);
  a_r9_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_flag_o && !(stat_we_i && stat_clr_i) |=> tmo_flag_o);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_req_i,
  input  logic       host_we_i,
  input  logic [1:0] host_addr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  output logic       host_ack_o,
  input  logic       epp_mode_i,
  input  logic [2:0] mode_i,
  input  logic       tmo_flag_i,
  output logic       mode_we_o,
  output logic       stat_we_o,
  input  logic       wait_s_i,
  input  logic       expired_i,
  output logic       run_o,
  output logic       tmo_set_o,
  output logic [7:0] pd_o,
  input  logic [7:0] pd_i,
  output logic       pd_oe_o,
  output logic       wr_line_no,
  output logic       addr_strobe_no,
  output logic       data_strobe_no
);
  epp_state_e state_q;
  logic       is_wr_q, is_addr_q;
  logic [7:0] wbyte_q;
  logic       accept, port_sel, port_go, reg_wr;

  assign accept   = host_req_i && !host_ack_o && (state_q == ST_IDLE);
  assign port_sel = (host_addr_i == ADDR_APORT) || (host_addr_i == ADDR_DPORT);
  assign port_go  = accept && port_sel && epp_mode_i;
  assign reg_wr   = accept && host_we_i;

  assign mode_we_o = reg_wr && (host_addr_i == ADDR_MODE);
  assign stat_we_o = reg_wr && (host_addr_i == ADDR_STAT);
  assign run_o     = (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign tmo_set_o = expired_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      is_wr_q      <= 1'b0;
      is_addr_q    <= 1'b0;
      wbyte_q      <= '0;
      host_ack_o   <= 1'b0;
      host_rdata_o <= '0;
    end else begin
      host_ack_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (port_go) begin
            is_wr_q      <= host_we_i;
            is_addr_q    <= (host_addr_i == ADDR_APORT);
            wbyte_q      <= host_wdata_i;
            host_rdata_o <= '0;
            state_q      <= ST_SETUP;
          end else if (accept) begin
            host_ack_o <= 1'b1;
            if (host_we_i) host_rdata_o <= '0;
            else begin
              unique case (host_addr_i)
                ADDR_STAT: host_rdata_o <= {7'b0, tmo_flag_i};
                ADDR_MODE: host_rdata_o <= {mode_i, 5'b0};
                default:   host_rdata_o <= '0;
              endcase
            end
          end
        end
        ST_SETUP: state_q <= ST_STROBE;
        ST_STROBE: begin
          if (expired_i) begin
            host_ack_o   <= 1'b1;
            host_rdata_o <= is_wr_q ? 8'h00 : ABORT_BYTE;
            state_q      <= ST_IDLE;
          end else if (wait_s_i) begin
            if (!is_wr_q) host_rdata_o <= pd_i;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (expired_i) begin
            host_ack_o   <= 1'b1;
            host_rdata_o <= is_wr_q ? 8'h00 : ABORT_BYTE;
            state_q      <= ST_IDLE;
          end else if (!wait_s_i) begin
            host_ack_o <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pd_oe_o        = is_wr_q && (state_q != ST_IDLE);
    wr_line_no     = !pd_oe_o;
    pd_o           = wbyte_q;
    addr_strobe_no = !((state_q == ST_STROBE) && is_addr_q);
    data_strobe_no = !((state_q == ST_STROBE) && !is_addr_q);
  end

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_strobe_no || data_strobe_no);
  a_r4_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(addr_strobe_no) || $fell(data_strobe_no)) && pd_oe_o
      |-> $past(pd_oe_o) && !$past(wr_line_no));
  a_r2_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epp_mode_i && !run_o |-> addr_strobe_no && data_strobe_no);
  a_r6_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);
  a_r6_hold_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_strobe_no && data_strobe_no) && !wait_s_i && !expired_i
      |=> !(addr_strobe_no && data_strobe_no));
endmodule

// File: rtl/epp_engine.sv
module epp_engine
  import epp_pkg::*;
#(
  parameter int unsigned TMO_CYCLES  = 2500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_req_i,
  input  logic       host_we_i,
  input  logic [1:0] host_addr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  output logic       host_ack_o,
  output logic [7:0] pd_o,
  input  logic [7:0] pd_i,
  output logic       pd_oe_o,
  output logic       wr_line_no,
  output logic       addr_strobe_no,
  output logic       data_strobe_no,
  input  logic       periph_wait_i
);
  logic       wait_s, expired, run, tmo_set;
  logic       mode_we, stat_we, epp_mode, tmo_flag;
  logic [2:0] mode;

  epp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(periph_wait_i), .q_o(wait_s)
  );

  epp_watchdog #(.TMO_CYCLES(TMO_CYCLES)) u_wdog (
    .clk_i, .rst_ni, .enable_i(epp_mode), .run_i(run), .expired_o(expired)
  );

  epp_regs u_regs (
    .clk_i, .rst_ni,
    .mode_we_i(mode_we), .mode_d_i(host_wdata_i[7:5]),
    .stat_we_i(stat_we), .stat_clr_i(host_wdata_i[0]),
    .tmo_set_i(tmo_set),
    .mode_o(mode), .tmo_flag_o(tmo_flag), .epp_mode_o(epp_mode)
  );

  epp_cycle_fsm u_fsm (
    .clk_i, .rst_ni,
    .host_req_i, .host_we_i, .host_addr_i, .host_wdata_i,
    .host_rdata_o, .host_ack_o,
    .epp_mode_i(epp_mode), .mode_i(mode), .tmo_flag_i(tmo_flag),
    .mode_we_o(mode_we), .stat_we_o(stat_we),
    .wait_s_i(wait_s), .expired_i(expired), .run_o(run), .tmo_set_o(tmo_set),
    .pd_o, .pd_i, .pd_oe_o, .wr_line_no, .addr_strobe_no, .data_strobe_no
  );

  a_r7_abort_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired |=> tmo_flag && host_ack_o);
endmodule

// File: tb/epp_engine_bench.sv
module epp_engine_bench;
  localparam int TMO = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pd_out, pd_in = '0;
  logic       ack, oe, wr_n, astb_n, dstb_n, pwait = 1'b0;

  int checks = 0, errors = 0;
  int pmode = 0;            // 0 normal, 1 dead, 2 wait never falls
  int rise_dly = 2, fall_dly = 2;
  logic [7:0] resp_byte = '0;
  bit check_hs = 1'b1;
  int strobe_events = 0, low_cycles = 0;
  logic prev_oe = 1'b0, prev_wrn = 1'b1, prev_strb = 1'b1;

  typedef struct packed { logic is_addr; logic is_wr; logic [7:0] b; } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  epp_engine #(.TMO_CYCLES(TMO), .SYNC_STAGES(2)) u_epp_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_ack_o(ack),
    .pd_o(pd_out), .pd_i(pd_in), .pd_oe_o(oe), .wr_line_no(wr_n),
    .addr_strobe_no(astb_n), .data_strobe_no(dstb_n), .periph_wait_i(pwait)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    logic strb;
    strb = astb_n && dstb_n;
    if (!strb) low_cycles++;
    if (prev_strb && !strb) strobe_events++;
    prev_strb = strb;
    prev_oe   = oe;
    prev_wrn  = wr_n;
  end

  // R6: a completed cycle acks only after WAIT# fell
  always @(negedge clk)
    if (ack && check_hs && pwait) chk("R6 ack before WAIT# fell", 1, 0);

  // peripheral model and scoreboard monitor
  initial forever begin
    item_t got, exp;
    @(negedge clk iff (!astb_n || !dstb_n));
    got.is_addr = !astb_n;
    got.is_wr   = !wr_n;
    got.b       = got.is_wr ? pd_out : resp_byte;
    if (exp_q.size() == 0) chk("R2 unexpected strobe", 1, 0);
    else begin
      exp = exp_q.pop_front();
      chk("R3 strobe kind/direction", {got.is_addr, got.is_wr}, {exp.is_addr, exp.is_wr});
      if (exp.is_wr) begin
        chk("R4 byte on port", got.b, exp.b);
        chk("R4 setup before strobe", {prev_oe, prev_wrn}, 2'b10);
      end else
        chk("R5 read lines undriven", {oe, wr_n}, 2'b01);
      chk("R3 one strobe", {astb_n, dstb_n} != 2'b00, 1);
    end
    if (pmode == 1) begin
      @(negedge clk iff (astb_n && dstb_n));
    end else begin
      repeat (rise_dly) begin
        @(negedge clk);
        if (got.is_wr) chk("R4 held during strobe", {oe, wr_n, pd_out}, {2'b10, exp.b});
        chk("R6 strobe held until WAIT#", astb_n && dstb_n, 0);
      end
      pwait = 1'b1;
      pd_in = resp_byte;
      @(negedge clk iff (astb_n && dstb_n));
      if (pmode == 2) @(negedge clk iff ack);
      else repeat (fall_dly) @(negedge clk);
      pwait = 1'b0;
    end
  end

  task automatic host_acc(input logic [1:0] a, input logic w, input logic [7:0] d,
                          output logic [7:0] r);
    @(negedge clk);
    addr = a; we = w; wdata = d; req = 1'b1;
    @(negedge clk iff ack);
    r = rdata;
    req = 1'b0;
  endtask

  task automatic port_acc(input logic is_a, input logic w, input logic [7:0] d,
                          output logic [7:0] r);
    item_t it;
    it.is_addr = is_a; it.is_wr = w; it.b = w ? d : resp_byte;
    exp_q.push_back(it);
    host_acc(is_a ? 2'd2 : 2'd3, w, d, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int ev;
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {astb_n, dstb_n, wr_n, oe, ack}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    host_acc(2'd1, 0, 0, r); chk("R1 mode reset", r, 8'h00);
    host_acc(2'd0, 0, 0, r); chk("R1 status reset", r, 8'h00);

    // R2, R10: port access outside EPP mode, peripheral dead
    pmode = 1; check_hs = 0;
    ev = strobe_events;
    host_acc(2'd3, 1, 8'h77, r);
    host_acc(2'd3, 0, 0, r); chk("R2 non-EPP read", r, 8'h00);
    host_acc(2'd1, 1, 8'h60, r);
    host_acc(2'd2, 0, 0, r); chk("R2 mode 011 read", r, 8'h00);
    repeat (TMO + 5) @(negedge clk);
    chk("R2 no strobe outside EPP", strobe_events - ev, 0);
    host_acc(2'd0, 0, 0, r); chk("R10 no timeout outside EPP", r, 8'h00);

    // R11: mode readback and non-EPP field 111
    host_acc(2'd1, 1, 8'hFF, r);
    host_acc(2'd1, 0, 0, r); chk("R11 mode readback", r, 8'hE0);
    ev = strobe_events;
    host_acc(2'd3, 0, 0, r);
    chk("R11 mode 111 not EPP", strobe_events - ev, 0);
    host_acc(2'd1, 1, 8'h9F, r);
    host_acc(2'd1, 0, 0, r); chk("R11 EPP mode readback", r, 8'h80);

    // R3, R4, R5, R6: normal handshakes
    pmode = 0; check_hs = 1;
    rise_dly = 2; fall_dly = 2;
    port_acc(0, 1, 8'hA5, r);
    port_acc(1, 1, 8'h3C, r);
    resp_byte = 8'h5A; rise_dly = 5;
    port_acc(0, 0, 0, r); chk("R5 data read", r, 8'h5A);
    resp_byte = 8'hC3; rise_dly = 1; fall_dly = 6;
    port_acc(1, 0, 0, r); chk("R5 address read", r, 8'hC3);
    host_acc(2'd0, 0, 0, r); chk("R6 no timeout on good cycle", r, 8'h00);

    // R7: dead peripheral on a data read
    pmode = 1; check_hs = 0;
    resp_byte = 8'hFF;
    low_cycles = 0;
    port_acc(0, 0, 0, r);
    chk("R7 abort read byte", r, 8'hFF);
    chk("R7 strobe low cycles", low_cycles, TMO);
    @(negedge clk);
    chk("R7 strobe released", {astb_n, dstb_n}, 2'b11);
    host_acc(2'd0, 0, 0, r); chk("R7 timeout flag", r, 8'h01);

    // R9: clear semantics
    host_acc(2'd0, 1, 8'hFE, r);
    host_acc(2'd0, 0, 0, r); chk("R9 write 0 keeps flag", r, 8'h01);
    host_acc(2'd0, 1, 8'h01, r);
    host_acc(2'd0, 0, 0, r); chk("R9 write 1 clears flag", r, 8'h00);

    // R8: WAIT# rises but never falls
    pmode = 2; rise_dly = 3;
    port_acc(1, 1, 8'h42, r);
    repeat (3) @(negedge clk);
    host_acc(2'd0, 0, 0, r); chk("R8 timeout in release phase", r, 8'h01);
    host_acc(2'd0, 1, 8'h01, r);

    // recovery after abort
    pmode = 0; check_hs = 1; rise_dly = 2; fall_dly = 1; resp_byte = 8'h96;
    port_acc(0, 0, 0, r); chk("R5 read after abort", r, 8'h96);
    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule